// File: doc/BRIEF.md
# Serial Host Command and Status Port

This block connects a host controller to a set of on-chip control registers over three wires: a shift clock, a data line and a load strobe. A fourth wire, the status line, carries replies back to the host. The shift clock and strobe pins are brought into the system clock domain and their rising edges are found there. The data pin is sampled at each detected shift clock edge. A write frame carries sixteen bits and loads one of five 8-bit control registers. A read frame carries an eight-bit command. The reply is then shifted out on the status line, one bit per host clock.

The status bytes, the buffer residual word and the levels at the general-purpose pins come into the block from outside. The block drives three general-purpose pins. The host sets which of them are outputs and what level each output drives. After a host has read the primary status byte, the block pulses a clear output so that the sticky flags behind that byte can reset. Each write to the memory control register also raises a one-cycle strobe. This lets downstream logic act on bits that only trigger an action.

Top module: `hcp_port`

## Requirements
- R1: A write frame is 16 bits shifted MSB first on rising shift clock edges: the data byte first, then the command byte. A rising strobe edge latches the frame.
- R2: Command codes 0x80, 0x81, 0x82, 0x83 and 0x85 load the memory control, pin direction, pin level, function and option registers. Any other code in a 16-bit frame changes no register. Reset clears every register bit to 0.
- R3: Each accepted 0x80 write raises `mem_ctl_stb` for exactly one clock. No other command raises it.
- R4: If a strobe arrives after fewer than 8 bits, or after any bit count other than 8 or 16, the frame is dropped and no register changes. The next frame starts from a bit count of zero.
- R5: After a read frame is latched, the reply's MSB appears on `host_sense`. Each later rising shift clock edge presents the next bit. Once the last bit has been shifted, `host_sense` returns to 0.
- R6: Read codes 0x90 and 0x91 return `st_primary` and `st_secondary` as 8 bits each.
- R7: Read code 0x92 returns `residual` as 16 bits, with the 5 least significant bits of the reply forced to 0.
- R8: Read code 0x93 returns 8 bits. Bits 2..0 are the levels present on `gp_in[2:0]`, and bits 7..3 are 0.
- R9: When the last bit of a 0x90 reply is shifted, `sticky_clr` pulses for one clock. Other reads never pulse it.
- R10: Bit i of the 0x81 register drives `gp_oe[i]`. A 0x82 level bit is accepted only for a pin that is already an output. For a pin that is an input, `gp_out[i]` keeps its previous level.
- R11: The shift clock and strobe pass through two synchronizer flops. A register therefore changes no sooner than the fourth system clock edge after the strobe pin rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sclk | input | 1 | Host shift clock |
| host_sdata | input | 1 | Host serial data |
| host_strobe | input | 1 | Host load strobe, rising edge latches |
| host_sense | output | 1 | Serial reply to host |
| st_primary | input | 8 | Primary status byte (sticky flags) |
| st_secondary | input | 8 | Secondary status byte |
| residual | input | 16 | Buffer residual word |
| gp_in | input | 3 | Levels present at the general-purpose pins |
| gp_out | output | 3 | Output levels for general-purpose pins |
| gp_oe | output | 3 | Output enables for general-purpose pins |
| mem_ctl | output | 8 | Memory control register |
| mem_ctl_stb | output | 1 | One-cycle pulse on each memory control write |
| fn_flags | output | 8 | Function flag register |
| opt_bits | output | 8 | Option register |
| sticky_clr | output | 1 | One-cycle clear for primary status flags |

## Verification
The bench uses the default parameters: a 16-bit frame, an 8-bit command, a 16-bit residual with 5 cleared low bits, three pins and two synchronizer stages. With a 16-bit residual, the 0x92 reply can be checked at full width, including the boundary between kept bits and forced-zero bits. With three pins, input and output pins can be mixed, so the direction gating of level writes can be observed bit by bit. With two synchronizer stages, the exact cycle at which a strobe takes effect can be pinned down.

// File: rtl/hcp_pkg.sv
package hcp_pkg;
  localparam logic [7:0] CMD_MEM = 8'h80;
  localparam logic [7:0] CMD_DIR = 8'h81;
  localparam logic [7:0] CMD_LVL = 8'h82;
  localparam logic [7:0] CMD_FUN = 8'h83;
  localparam logic [7:0] CMD_OPT = 8'h85;
  localparam logic [7:0] CMD_ST0 = 8'h90;
  localparam logic [7:0] CMD_ST1 = 8'h91;
  localparam logic [7:0] CMD_RES = 8'h92;
  localparam logic [7:0] CMD_PIN = 8'h93;

  typedef enum logic [2:0] {
    WSEL_NONE,
    WSEL_MEM,
    WSEL_DIR,
    WSEL_LVL,
    WSEL_FUN,
    WSEL_OPT
  } wsel_e;
endpackage

// File: rtl/hcp_edge_sync.sv
module hcp_edge_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain_q, chain_d;
    logic              prev_q;

    always_comb chain_d = {chain_q[STAGES-2:0], din[i]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= chain_d;
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign rise[i] = chain_q[STAGES-1] & ~prev_q;

    // R11
    edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> !rise[i]);
  end
endmodule

// File: rtl/hcp_frame_rx.sv
module hcp_frame_rx #(
  parameter int CMD_W   = 8,
  parameter int FRAME_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_rise,
  input  logic             strobe_rise,
  input  logic             din,
  input  logic             hold,
  output logic             wr_ev,
  output logic             rd_ev,
  output logic [CMD_W-1:0] cmd,
  output logic [FRAME_W-CMD_W-1:0] data
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_CMD  = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               wr_q, wr_d, rd_q, rd_d;
  logic [CMD_W-1:0]   cmd_q, cmd_d;
  logic [FRAME_W-CMD_W-1:0] data_q, data_d;

  always_comb begin
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    wr_d   = 1'b0;
    rd_d   = 1'b0;
    cmd_d  = cmd_q;
    data_d = data_q;
    if (strobe_rise) begin
      cnt_d = '0;
      if (cnt_q == CNT_FULL) begin
        wr_d   = 1'b1;
        cmd_d  = sr_q[CMD_W-1:0];
        data_d = sr_q[FRAME_W-1:CMD_W];
      end else if (cnt_q == CNT_CMD) begin
        rd_d  = 1'b1;
        cmd_d = sr_q[CMD_W-1:0];
      end
    end else if (bit_rise && !hold) begin
      sr_d = {sr_q[FRAME_W-2:0], din};
      if (cnt_q != CNT_OVER) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      cmd_q  <= cmd_d;
      data_q <= data_d;
    end
  end

  assign wr_ev = wr_q;
  assign rd_ev = rd_q;
  assign cmd   = cmd_q;
  assign data  = data_q;

  // R1
  frame_kind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_q && rd_q));
  // R4
  frame_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_OVER);
  // R1
  frame_wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |=> !wr_q);
endmodule

// File: rtl/hcp_regs.sv
module hcp_regs
  import hcp_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int GP_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ev,
  input  logic [7:0]       cmd,
  input  logic [REG_W-1:0] data,
  output logic [REG_W-1:0] mem_ctl,
  output logic             mem_stb,
  output logic [GP_W-1:0]  dir,
  output logic [GP_W-1:0]  lvl,
  output logic [REG_W-1:0] fn,
  output logic [REG_W-1:0] opt
);
  wsel_e                sel;
  logic [REG_W-1:0]     mem_q, mem_d, fn_q, fn_d, opt_q, opt_d;
  logic [GP_W-1:0]      dir_q, dir_d, lvl_q, lvl_d;
  logic                 stb_q, stb_d;

  always_comb begin
    sel = WSEL_NONE;
    if (wr_ev) begin
      case (cmd)
        CMD_MEM: sel = WSEL_MEM;
        CMD_DIR: sel = WSEL_DIR;
        CMD_LVL: sel = WSEL_LVL;
        CMD_FUN: sel = WSEL_FUN;
        CMD_OPT: sel = WSEL_OPT;
        default: sel = WSEL_NONE;
      endcase
    end
  end

  always_comb begin
    mem_d = mem_q;
    dir_d = dir_q;
    lvl_d = lvl_q;
    fn_d  = fn_q;
    opt_d = opt_q;
    stb_d = 1'b0;
    case (sel)
      WSEL_MEM: begin
        mem_d = data;
        stb_d = 1'b1;
      end
      WSEL_DIR: dir_d = data[GP_W-1:0];
      WSEL_LVL: lvl_d = (lvl_q & ~dir_q) | (data[GP_W-1:0] & dir_q);
      WSEL_FUN: fn_d  = data;
      WSEL_OPT: opt_d = data;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      dir_q <= '0;
      lvl_q <= '0;
      fn_q  <= '0;
      opt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      mem_q <= mem_d;
      dir_q <= dir_d;
      lvl_q <= lvl_d;
      fn_q  <= fn_d;
      opt_q <= opt_d;
      stb_q <= stb_d;
    end
  end

  assign mem_ctl = mem_q;
  assign mem_stb = stb_q;
  assign dir     = dir_q;
  assign lvl     = lvl_q;
  assign fn      = fn_q;
  assign opt     = opt_q;

  // R3
  mem_change_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_q) |-> stb_q);
  // R3
  mem_stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);
  // R10
  lvl_input_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl_q ^ $past(lvl_q)) & ~dir_q) == '0);
endmodule

// File: rtl/hcp_reply_tx.sv
module hcp_reply_tx
  import hcp_pkg::*;
#(
  parameter int RES_W    = 16,
  parameter int RES_ZERO = 5,
  parameter int GP_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_ev,
  input  logic [7:0]       cmd,
  input  logic             bit_rise,
  input  logic             strobe_rise,
  input  logic [7:0]       st0,
  input  logic [7:0]       st1,
  input  logic [RES_W-1:0] res,
  input  logic [GP_W-1:0]  pins,
  output logic             sense,
  output logic             active,
  output logic             clr
);
  localparam int LEFT_W = $clog2(RES_W + 1);
  localparam logic [RES_W-1:0] RES_MASK = {{(RES_W-RES_ZERO){1'b1}}, {RES_ZERO{1'b0}}};
  localparam logic [LEFT_W-1:0] LEN_BYTE = LEFT_W'(8);
  localparam logic [LEFT_W-1:0] LEN_RES  = LEFT_W'(RES_W);

  logic [RES_W-1:0]  sr_q, sr_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              act_q, act_d, arm_q, arm_d, clr_q, clr_d, isres_q, isres_d;

  always_comb begin
    sr_d    = sr_q;
    left_d  = left_q;
    act_d   = act_q;
    arm_d   = arm_q;
    isres_d = isres_q;
    clr_d   = 1'b0;
    if (rd_ev) begin
      act_d   = 1'b1;
      arm_d   = 1'b0;
      isres_d = 1'b0;
      left_d  = LEN_BYTE;
      case (cmd)
        CMD_ST0: begin
          sr_d  = {st0, {(RES_W-8){1'b0}}};
          arm_d = 1'b1;
        end
        CMD_ST1: sr_d = {st1, {(RES_W-8){1'b0}}};
        CMD_RES: begin
          sr_d    = res & RES_MASK;
          left_d  = LEN_RES;
          isres_d = 1'b1;
        end
        CMD_PIN: sr_d = {{(8-GP_W){1'b0}}, pins, {(RES_W-8){1'b0}}};
        default: begin
          act_d  = 1'b0;
          left_d = '0;
        end
      endcase
    end else if (strobe_rise && act_q) begin
      act_d  = 1'b0;
      arm_d  = 1'b0;
      left_d = '0;
    end else if (bit_rise && act_q) begin
      sr_d   = {sr_q[RES_W-2:0], 1'b0};
      left_d = left_q - 1'b1;
      if (left_q == LEFT_W'(1)) begin
        act_d = 1'b0;
        clr_d = arm_q;
        arm_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      left_q  <= '0;
      act_q   <= 1'b0;
      arm_q   <= 1'b0;
      clr_q   <= 1'b0;
      isres_q <= 1'b0;
    end else begin
      sr_q    <= sr_d;
      left_q  <= left_d;
      act_q   <= act_d;
      arm_q   <= arm_d;
      clr_q   <= clr_d;
      isres_q <= isres_d;
    end
  end

  assign sense  = act_q & sr_q[RES_W-1];
  assign active = act_q;
  assign clr    = clr_q;

  // R5
  reply_len_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (left_q != '0));
  // R9
  clr_after_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> (!act_q && $past(act_q)));
  // R9
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !clr_q);
  // R7
  res_tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && isres_q && (left_q <= LEFT_W'(RES_ZERO))) |-> !sense);
endmodule

// File: rtl/hcp_port.sv
module hcp_port #(
  parameter int CMD_W    = 8,
  parameter int FRAME_W  = 16,
  parameter int RES_W    = 16,
  parameter int RES_ZERO = 5,
  parameter int GP_W     = 3,
  parameter int STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_sclk,
  input  logic             host_sdata,
  input  logic             host_strobe,
  output logic             host_sense,
  input  logic [7:0]       st_primary,
  input  logic [7:0]       st_secondary,
  input  logic [RES_W-1:0] residual,
  input  logic [GP_W-1:0]  gp_in,
  output logic [GP_W-1:0]  gp_out,
  output logic [GP_W-1:0]  gp_oe,
  output logic [7:0]       mem_ctl,
  output logic             mem_ctl_stb,
  output logic [7:0]       fn_flags,
  output logic [7:0]       opt_bits,
  output logic             sticky_clr
);
  localparam int REG_W = FRAME_W - CMD_W;

  logic [1:0]       rise;
  logic             wr_ev, rd_ev, reply_active;
  logic [CMD_W-1:0] cmd;
  logic [REG_W-1:0] data;

  hcp_edge_sync #(.N(2), .STAGES(STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({host_strobe, host_sclk}),
    .rise (rise)
  );

  hcp_frame_rx #(.CMD_W(CMD_W), .FRAME_W(FRAME_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_rise   (rise[0]),
    .strobe_rise(rise[1]),
    .din        (host_sdata),
    .hold       (reply_active),
    .wr_ev      (wr_ev),
    .rd_ev      (rd_ev),
    .cmd        (cmd),
    .data       (data)
  );

  hcp_regs #(.REG_W(REG_W), .GP_W(GP_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ev  (wr_ev),
    .cmd    (cmd),
    .data   (data),
    .mem_ctl(mem_ctl),
    .mem_stb(mem_ctl_stb),
    .dir    (gp_oe),
    .lvl    (gp_out),
    .fn     (fn_flags),
    .opt    (opt_bits)
  );

  hcp_reply_tx #(.RES_W(RES_W), .RES_ZERO(RES_ZERO), .GP_W(GP_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_ev      (rd_ev),
    .cmd        (cmd),
    .bit_rise   (rise[0]),
    .strobe_rise(rise[1]),
    .st0        (st_primary),
    .st1        (st_secondary),
    .res        (residual),
    .pins       (gp_in),
    .sense      (host_sense),
    .active     (reply_active),
    .clr        (sticky_clr)
  );

  // R2
  reset_state_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (mem_ctl == '0 && fn_flags == '0 && opt_bits == '0 && gp_oe == '0));
endmodule

// File: tb/hcp_port_bench.sv
`timescale 1ns/1ps
module hcp_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, sdata = 1'b0, strobe = 1'b0;
  logic        sense;
  logic [7:0]  st0 = 8'h00, st1 = 8'h00;
  logic [15:0] res = 16'h0000;
  logic [2:0]  ext = 3'b000;
  logic [2:0]  gp_in, gp_out, gp_oe;
  logic [7:0]  mem, fn, opt;
  logic        stb, clr;
  int          total = 0, bad = 0, stb_cnt = 0, clr_cnt = 0;

  always #2.5 clk = ~clk;

  assign gp_in = (gp_oe & gp_out) | (~gp_oe & ext);

  hcp_port u_hcp_port (
    .clk(clk), .rst_n(rst_n), .host_sclk(sclk), .host_sdata(sdata),
    .host_strobe(strobe), .host_sense(sense), .st_primary(st0),
    .st_secondary(st1), .residual(res), .gp_in(gp_in), .gp_out(gp_out),
    .gp_oe(gp_oe), .mem_ctl(mem), .mem_ctl_stb(stb), .fn_flags(fn),
    .opt_bits(opt), .sticky_clr(clr)
  );

  always @(negedge clk) begin
    if (stb) stb_cnt++;
    if (clr) clr_cnt++;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) sdata = v[i];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic pulse_strobe();
    @(negedge clk) strobe = 1'b1;
    repeat (8) @(negedge clk);
    strobe = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] c, input logic [7:0] d);
    send_bits({d, c}, 16);
    pulse_strobe();
  endtask

  task automatic do_read(input logic [7:0] c, input int n, output logic [15:0] got);
    got = '0;
    send_bits({8'h00, c}, 8);
    pulse_strobe();
    for (int i = 0; i < n; i++) begin
      got = {got[14:0], sense};
      @(negedge clk) sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
      repeat (8) @(negedge clk);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R2 reset mem", mem, 0);
    check("R2 reset fn", fn, 0);
    check("R2 reset opt", opt, 0);
    check("R10 reset oe/out", {gp_oe, gp_out}, 0);
    check("R5 reset sense", sense, 0);
  endtask

  task automatic t_latency();
    int s0;
    s0 = stb_cnt;
    send_bits({8'hA5, 8'h80}, 16);
    @(negedge clk) strobe = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R11 no early update", mem, 8'h00);
    repeat (6) @(negedge clk);
    check("R1 mem write", mem, 8'hA5);
    strobe = 1'b0;
    repeat (8) @(negedge clk);
    check("R3 one stb pulse", stb_cnt - s0, 1);
  endtask

  task automatic t_other_regs();
    int s0;
    s0 = stb_cnt;
    do_write(8'h83, 8'h3C);
    check("R2 fn write", fn, 8'h3C);
    do_write(8'h85, 8'h81);
    check("R2 opt write", opt, 8'h81);
    do_write(8'h84, 8'hFF);
    check("R2 unknown code ignored", {mem, fn, opt, gp_oe, gp_out}, {8'hA5, 8'h3C, 8'h81, 6'b0});
    check("R3 no stb on other codes", stb_cnt - s0, 0);
  endtask

  task automatic t_abort();
    send_bits(16'h0080, 5);
    pulse_strobe();
    check("R4 short frame ignored", mem, 8'hA5);
    send_bits(16'h0F80, 12);
    pulse_strobe();
    check("R4 odd count ignored", mem, 8'hA5);
    do_write(8'h80, 8'h0F);
    check("R4 count restarts", mem, 8'h0F);
  endtask

  task automatic t_gpio();
    logic [15:0] got;
    do_write(8'h82, 8'h07);
    check("R10 level on input pins held", gp_out, 3'b000);
    do_write(8'h81, 8'h05);
    check("R10 direction", gp_oe, 3'b101);
    do_write(8'h82, 8'h07);
    check("R10 level on outputs", gp_out, 3'b101);
    ext = 3'b000;
    do_read(8'h93, 8, got);
    check("R8 pin read", got[7:0], 8'h05);
    ext = 3'b010;
    do_read(8'h93, 8, got);
    check("R8 pin read input high", got[7:0], 8'h07);
  endtask

  task automatic t_status();
    logic [15:0] got;
    int c0;
    st0 = 8'h5A;
    st1 = 8'hC3;
    c0 = clr_cnt;
    do_read(8'h90, 8, got);
    check("R6 primary status", got[7:0], 8'h5A);
    check("R9 clear pulse after 0x90", clr_cnt - c0, 1);
    check("R5 sense idle after reply", sense, 0);
    c0 = clr_cnt;
    do_read(8'h91, 8, got);
    check("R6 secondary status", got[7:0], 8'hC3);
    check("R9 no clear after 0x91", clr_cnt - c0, 0);
  endtask

  task automatic t_residual();
    logic [15:0] got;
    res = 16'hFFFF;
    do_read(8'h92, 16, got);
    check("R7 residual all ones", got, 16'hFFE0);
    res = 16'h1234;
    do_read(8'h92, 16, got);
    check("R7 residual pattern", got, 16'h1220);
    check("R5 sense idle after residual", sense, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_latency();
    t_other_regs();
    t_abort();
    t_gpio();
    t_status();
    t_residual();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule